// File: doc/BRIEF.md
# Zero-Crossing XOR Phase Meter

The block reports the phase shift between two single-tone sample streams that a band-pass stage has already cleaned up. A sign relay on each stream turns the samples into a square wave. While the two relays disagree, a gate is high. A window counter clocked by the system clock counts how many clock cycles the gate is high across exactly one injection period, and that period is supplied in clocks. One period holds both the rising and the falling disagreement intervals, so the high count over a window maps linearly onto 0 to 180 degrees.

The phase is not taken from a single window. The block adds up the gate-high counts and the window lengths over a fixed number of consecutive windows, 100 by default. At the end of that set it runs one shared sequential divide, which gives 180·Σhigh/Σlength with two fractional bits. The result is held on the output and a one-cycle valid pulse announces it. Because the divisor is the sum of the real window lengths, a change of period partway through a set still gives a consistent ratio.

Top module: `phase_xor_meter`

## Requirements
- R1: On a clock edge with `samp_valid` high, a channel's relay becomes 1 if its two's-complement sample is greater than zero, and becomes 0 if the sample is negative. Both relays are 0 after reset.
- R2: A sample of exactly zero leaves that channel's relay unchanged.
- R3: While `samp_valid` is low, neither relay changes, whatever the sample values are.
- R4: Every clock edge of a window adds one to the window's high count when the two relays differ at that edge. A square wave delayed by D clocks against another of period P therefore gives a count of 2·D for D ≤ P/2.
- R5: A window lasts `period_clks` clocks. The value is taken at the edge that closes the previous window, so a new period takes effect from the next window.
- R6: While the latched window length is zero, no window runs and no new result appears. Measurement restarts once `period_clks` becomes nonzero.
- R7: After every NAVG closed windows, `phase_deg` equals floor(180·4·Σhigh / Σlength). The unit is a quarter degree (two fractional bits), and the quotient is rounded down.
- R8: `phase_valid` is high for exactly one cycle per new result. `phase_deg` keeps its value between results.
- R9: After reset, `phase_deg` is 0 and `phase_valid` is 0.
- R10: Relays that always agree give 0. Relays that always disagree give 720 (180.00 degrees).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the time base for the count |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_valid | input | 1 | Both sample inputs hold a new sample |
| samp_a | input | SAMP_W | Reference-side filtered sample, signed |
| samp_b | input | SAMP_W | Loop-side filtered sample, signed |
| period_clks | input | PER_W | Injection period in system clocks; 0 halts measurement |
| phase_deg | output | PH_W | Averaged phase in quarter degrees |
| phase_valid | output | 1 | One-cycle strobe for a new `phase_deg` |

## Verification
Two events can fall in the same cycle. One is a relay flip, and the other is the edge that closes a counting window. When that closing edge also completes the last window of a set, the handover of the sums to the divider happens in the same cycle too. To provoke these cases, the directed scenarios drive square waves whose period equals the window length, and they change the delay, the period and the strobe spacing. As a result, relay transitions land on every position inside a window, the closing edge included. Each result is judged against the exact floor value 180·4·2D/P. A cycle lost or counted twice at a window boundary or at the set boundary moves the quotient away from that value.

// File: rtl/phase_pkg.sv
// Package shared by the phase meter modules.
// Holds the half-turn scale constant and the state type of the divider.
package phase_pkg;
    localparam int unsigned HALF_TURN_DEG = 180;

    typedef enum logic {
        DIV_IDLE = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_t;
endpackage

// File: rtl/sign_relay.sv
// sign_relay: turns a signed sample stream into a one-bit sign state.
// Assumes: the sample is two's complement and is valid only when strobe is high.
// A zero sample keeps the previous state, which gives hysteresis at the crossing.
module sign_relay #(
    parameter int unsigned SW = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 strobe,
    input  logic signed [SW-1:0] sample,
    output logic                 sgn
);
    logic is_zero;
    assign is_zero = (sample == '0);

    // Update the sign on strobed, nonzero samples only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sgn <= 1'b0;
        end else if (strobe && !is_zero) begin
            sgn <= ~sample[SW-1];
        end
    end

    // R1: a positive strobed sample drives the relay high
    a_r1_positive_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !sample[SW-1] && !is_zero) |=> sgn);
    // R1: a negative strobed sample drives the relay low
    a_r1_negative_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && sample[SW-1]) |=> !sgn);
    // R2: a zero sample does not move the relay
    a_r2_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && is_zero) |=> $stable(sgn));
    // R3: no strobe, no change
    a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(sgn));
endmodule

// File: rtl/xor_window_counter.sv
// xor_window_counter: counts the clock edges, within one window, at which the two relays differ.
// Assumes: the window length is latched at the edge that closes the previous window.
// A latched length of zero holds the counter idle. Each window reports its high count and its length.
module xor_window_counter #(
    parameter int unsigned PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sgn_a,
    input  logic          sgn_b,
    input  logic [PW-1:0] period,
    output logic          win_done,
    output logic [PW-1:0] win_hi,
    output logic [PW-1:0] win_len
);
    logic [PW-1:0] len_q;
    logic [PW-1:0] pos_q;
    logic [PW-1:0] hi_q;
    logic          gate;
    logic          last;

    assign gate = sgn_a ^ sgn_b;
    assign last = (pos_q == len_q - PW'(1));

    // Window sequencing: idle, count, or close and relatch the length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q    <= '0;
            pos_q    <= '0;
            hi_q     <= '0;
            win_done <= 1'b0;
            win_hi   <= '0;
            win_len  <= '0;
        end else begin
            win_done <= 1'b0;
            if (len_q == '0) begin
                len_q <= period;
                pos_q <= '0;
                hi_q  <= '0;
            end else if (last) begin
                win_done <= 1'b1;
                win_hi   <= hi_q + PW'(gate);
                win_len  <= len_q;
                len_q    <= period;
                pos_q    <= '0;
                hi_q     <= '0;
            end else begin
                pos_q <= pos_q + PW'(1);
                hi_q  <= hi_q + PW'(gate);
            end
        end
    end

    // R4: a window never reports more high edges than it has edges
    a_r4_hi_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> (win_hi <= win_len));
    // R6: an idle counter closes no window
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (len_q == '0) |=> !win_done);
    // R5: a reported window always has a nonzero length
    a_r5_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> (win_len != '0));
endmodule

// File: rtl/phase_averager.sv
// phase_averager: sums the high counts and the lengths over NAVG windows, then hands both to the divider.
// Assumes: NAVG >= 2. The divider is idle again before the next set completes.
// The numerator is scaled by 180 * 2^FRAC.
module phase_averager import phase_pkg::*; #(
    parameter int unsigned PW   = 16,
    parameter int unsigned NAVG = 100,
    parameter int unsigned FRAC = 2,
    localparam int unsigned SCALE = HALF_TURN_DEG << FRAC,
    localparam int unsigned QW    = $clog2(SCALE + 1),
    localparam int unsigned SW    = PW + $clog2(NAVG + 1),
    localparam int unsigned NUMW  = SW + QW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            win_done,
    input  logic [PW-1:0]   win_hi,
    input  logic [PW-1:0]   win_len,
    output logic            div_go,
    output logic [NUMW-1:0] num,
    output logic [SW-1:0]   den
);
    localparam int unsigned CW = $clog2(NAVG);

    logic [SW-1:0] hi_sum;
    logic [SW-1:0] len_sum;
    logic [CW-1:0] n_q;
    logic [SW-1:0] hi_next;
    logic [SW-1:0] len_next;

    assign hi_next  = hi_sum + SW'(win_hi);
    assign len_next = len_sum + SW'(win_len);

    // Accumulate each window; on the last window of a set, launch the divide
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_sum  <= '0;
            len_sum <= '0;
            n_q     <= '0;
            div_go  <= 1'b0;
            num     <= '0;
            den     <= '0;
        end else begin
            div_go <= 1'b0;
            if (win_done) begin
                if (n_q == CW'(NAVG - 1)) begin
                    div_go  <= 1'b1;
                    num     <= NUMW'(hi_next) * NUMW'(SCALE);
                    den     <= len_next;
                    hi_sum  <= '0;
                    len_sum <= '0;
                    n_q     <= '0;
                end else begin
                    hi_sum  <= hi_next;
                    len_sum <= len_next;
                    n_q     <= n_q + CW'(1);
                end
            end
        end
    end

    // R7: the window index stays inside one averaging set
    a_r7_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        n_q < CW'(NAVG));
    // R7: a launched divide always has at least NAVG clocks in its divisor
    a_r7_den_floor: assert property (@(posedge clk) disable iff (!rst_n)
        div_go |-> (den >= SW'(NAVG)));
endmodule

// File: rtl/seq_divider.sv
// seq_divider: restoring divider that produces one quotient bit per clock.
// Assumes: the quotient fits in QW bits (the numerator is below den * 2^QW).
// go arrives only while the divider is idle. The quotient is held until the next result.
module seq_divider import phase_pkg::*; #(
    parameter int unsigned NUMW = 33,
    parameter int unsigned DENW = 23,
    parameter int unsigned QW   = 10,
    parameter int unsigned QMAX = 720
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic [NUMW-1:0] num,
    input  logic [DENW-1:0] den,
    output logic            q_valid,
    output logic [QW-1:0]   quot
);
    localparam int unsigned SCW = $clog2(QW + 1);

    div_state_t       st;
    logic [NUMW-1:0]  rem_q;
    logic [NUMW-1:0]  dsh_q;
    logic [QW-1:0]    acc_q;
    logic [SCW-1:0]   sc_q;
    logic             take;
    logic [QW-1:0]    acc_next;

    // One trial subtraction per step
    always_comb begin
        take     = (rem_q >= dsh_q);
        acc_next = {acc_q[QW-2:0], take};
    end

    // Load on go, run QW steps, publish the quotient
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= DIV_IDLE;
            rem_q   <= '0;
            dsh_q   <= '0;
            acc_q   <= '0;
            sc_q    <= '0;
            q_valid <= 1'b0;
            quot    <= '0;
        end else begin
            q_valid <= 1'b0;
            case (st)
                DIV_IDLE: begin
                    if (go) begin
                        rem_q <= num;
                        dsh_q <= NUMW'(den) << (QW - 1);
                        acc_q <= '0;
                        sc_q  <= SCW'(QW);
                        st    <= DIV_RUN;
                    end
                end
                DIV_RUN: begin
                    if (take) begin
                        rem_q <= rem_q - dsh_q;
                    end
                    acc_q <= acc_next;
                    dsh_q <= dsh_q >> 1;
                    sc_q  <= sc_q - SCW'(1);
                    if (sc_q == SCW'(1)) begin
                        quot    <= acc_next;
                        q_valid <= 1'b1;
                        st      <= DIV_IDLE;
                    end
                end
                default: st <= DIV_IDLE;
            endcase
        end
    end

    // R8: a divide is never started while one is running
    a_r8_go_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (st == DIV_IDLE));
    // R7: the published phase never exceeds half a turn
    a_r7_quot_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |-> (quot <= QW'(QMAX)));
    // R8: the result strobe lasts one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |=> !q_valid);
    // R8: the result holds between strobes
    a_r8_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !q_valid |-> $stable(quot));
endmodule

// File: rtl/phase_xor_meter.sv
// phase_xor_meter: top level of the zero-crossing XOR phase meter.
// Assumes: both sample streams share one strobe, and period_clks is the injection period in clocks.
// The output is in quarter degrees (FRAC fractional bits) and is averaged over NAVG windows.
module phase_xor_meter import phase_pkg::*; #(
    parameter int unsigned SAMP_W = 12,
    parameter int unsigned PER_W  = 16,
    parameter int unsigned NAVG   = 100,
    parameter int unsigned FRAC   = 2,
    localparam int unsigned PH_W  = $clog2((HALF_TURN_DEG << FRAC) + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     samp_valid,
    input  logic signed [SAMP_W-1:0] samp_a,
    input  logic signed [SAMP_W-1:0] samp_b,
    input  logic [PER_W-1:0]         period_clks,
    output logic [PH_W-1:0]          phase_deg,
    output logic                     phase_valid
);
    localparam int unsigned SCALE = HALF_TURN_DEG << FRAC;
    localparam int unsigned SW    = PER_W + $clog2(NAVG + 1);
    localparam int unsigned NUMW  = SW + PH_W;

    logic signed [SAMP_W-1:0] lane [2];
    logic [1:0]               sgn;
    logic                     win_done;
    logic [PER_W-1:0]         win_hi;
    logic [PER_W-1:0]         win_len;
    logic                     div_go;
    logic [NUMW-1:0]          num;
    logic [SW-1:0]            den;

    assign lane[0] = samp_a;
    assign lane[1] = samp_b;

    // One sign relay per input channel
    for (genvar g = 0; g < 2; g++) begin : g_relay
        sign_relay #(.SW(SAMP_W)) i_relay (
            .clk    (clk),
            .rst_n  (rst_n),
            .strobe (samp_valid),
            .sample (lane[g]),
            .sgn    (sgn[g])
        );
    end

    xor_window_counter #(.PW(PER_W)) i_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .sgn_a    (sgn[0]),
        .sgn_b    (sgn[1]),
        .period   (period_clks),
        .win_done (win_done),
        .win_hi   (win_hi),
        .win_len  (win_len)
    );

    phase_averager #(.PW(PER_W), .NAVG(NAVG), .FRAC(FRAC)) i_avg (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_done (win_done),
        .win_hi   (win_hi),
        .win_len  (win_len),
        .div_go   (div_go),
        .num      (num),
        .den      (den)
    );

    seq_divider #(.NUMW(NUMW), .DENW(SW), .QW(PH_W), .QMAX(SCALE)) i_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (div_go),
        .num     (num),
        .den     (den),
        .q_valid (phase_valid),
        .quot    (phase_deg)
    );

    // R9: the output is quiet in the cycle after reset
    a_r9_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!phase_valid && phase_deg == '0));
endmodule

// File: tb/test_phase_xor_meter.sv
// Directed bench for phase_xor_meter: one task per scenario, each checking its own result.
module test_phase_xor_meter;
    localparam int SW   = 12;
    localparam int PW   = 16;
    localparam int PH_W = 10;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 samp_valid = 1'b0;
    logic signed [SW-1:0] samp_a = '0;
    logic signed [SW-1:0] samp_b = '0;
    logic [PW-1:0]        period_clks = '0;
    logic [PH_W-1:0]      phase_deg;
    logic                 phase_valid;

    int n_run  = 0;
    int n_fail = 0;

    // stimulus configuration: mode 0 = square waves, 1 = constants
    int gen_mode = 1;
    int cfg_p = 40;
    int cfg_d = 5;
    bit cfg_sparse = 1'b0;
    int const_a = 0;
    int const_b = 0;
    bit const_strobe = 1'b0;
    int t = 0;

    phase_xor_meter i_phase_xor_meter (
        .clk         (clk),
        .rst_n       (rst_n),
        .samp_valid  (samp_valid),
        .samp_a      (samp_a),
        .samp_b      (samp_b),
        .period_clks (period_clks),
        .phase_deg   (phase_deg),
        .phase_valid (phase_valid)
    );

    always #4 clk = ~clk;

    // Sample generator, driven at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            t++;
            if (gen_mode == 0) begin
                samp_a     <= ((t % cfg_p) < cfg_p / 2) ? SW'(300) : -SW'(250);
                samp_b     <= (((t + cfg_p - cfg_d) % cfg_p) < cfg_p / 2) ? SW'(180) : -SW'(410);
                samp_valid <= cfg_sparse ? ((t % 2) == 0) : 1'b1;
            end else begin
                samp_a     <= SW'(const_a);
                samp_b     <= SW'(const_b);
                samp_valid <= const_strobe;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Wait for one result; also judge the one-cycle strobe and the hold (R8)
    task automatic wait_result(input string req, output int val);
        int waited = 0;
        val = -1;
        while (!phase_valid && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        if (!phase_valid) begin
            check({req, " timeout"}, 0, 1);
        end else begin
            val = int'(phase_deg);
            @(negedge clk);
            check("R8 strobe one cycle", int'(phase_valid), 0);
            check("R8 value held", int'(phase_deg), val);
        end
    endtask

    // Discard the mixed result after a change, then judge the next one
    task automatic settle_and_check(input string req, input int exp);
        int v;
        wait_result(req, v);
        wait_result(req, v);
        check(req, v, exp);
    endtask

    task automatic square(input int p, input int d, input bit sparse, input string req);
        cfg_p = p; cfg_d = d; cfg_sparse = sparse; gen_mode = 0;
        period_clks = PW'(p);
        settle_and_check(req, (720 * 2 * d) / p);
    endtask

    task automatic constants(input int a, input int b, input bit stb, input int exp, input string req);
        const_a = a; const_b = b; const_strobe = stb; gen_mode = 1;
        period_clks = PW'(32);
        settle_and_check(req, exp);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R9 phase after reset", int'(phase_deg), 0);
        check("R9 valid after reset", int'(phase_valid), 0);
    endtask

    task automatic t_halt;
        int seen = 0;
        period_clks = '0;
        repeat (200) @(negedge clk);
        repeat (3000) begin
            @(negedge clk);
            if (phase_valid) seen++;
        end
        check("R6 no result while period is zero", seen, 0);
        square(40, 5, 1'b0, "R6 resumes after period returns");
    endtask

    initial begin
        #(8 * 190000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        constants(5, -9, 1'b1, 720, "R10 opposite signs R1 negative");
        constants(5, 0, 1'b1, 720, "R2 zero sample keeps relay");
        constants(5, 7, 1'b1, 0, "R10 same signs R1 positive");
        constants(5, -9, 1'b0, 0, "R3 no strobe keeps relays");
        square(40, 5, 1'b0, "R4 delay 5 of 40");
        square(36, 5, 1'b0, "R5 new period 36");
        square(28, 3, 1'b0, "R7 floor of 4320/28");
        square(40, 6, 1'b1, "R4 sparse strobe");
        square(40, 20, 1'b0, "R10 half period delay");
        t_halt();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule